// File: doc/BRIEF.md
# Switch Port Ingress Controller

This block sits between a port's receive MAC and the shared packet buffer of a switch. Frame data arrives as 16-bit words together with a last-word flag, a half-word flag for odd-length frames, a per-word error flag and a frame-check result that is valid on the last word. The block captures the destination address early and raises a forwarding lookup. It packs the words into 64-bit quad-words for the buffer-write FIFO. It decides when the frame is handed to the destination output queue, and after a clean frame it raises a source-address learning request.

Two switching modes are offered. In store-and-forward mode the enqueue waits for the end of a clean frame. In cut-through mode the enqueue fires as soon as a programmable number of bytes has been accepted. The mode and the byte threshold are taken once per frame, at its first word. Every frame ends with exactly one outcome: an enqueue, either earlier or at the end, or a drop indication. The forwarding table, the buffer memory and the output queues sit outside the block and are reached through single-cycle valid pulses.

Top module: `port_ingress_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, lookupValid, fifoValid, enqValid, learnValid and dropValid are all low.
- R2: A one-cycle lookupValid pulse follows the edge that accepts word 2 (counting from 0) of a frame, unless rxErr was seen on words 0 to 2. lookupDa is {word2, word1, word0}, so the first received byte sits in bits 7:0.
- R3: Word j of a quad-word (j = 0..3) occupies fifoData bits 16j+15 down to 16j. A FIFO write pulse follows the edge that accepts the fourth word of a quad-word. A write that is not the frame's last carries fifoBytes = 8.
- R4: The last word of a frame always causes a write with fifoLast = 1, where fifoBytes is the count of valid bytes (1 to 8). If rxHalf is set with rxLast, only the low byte of that word is valid. Bytes that are not valid read as zero. On that write fifoBad = 1 if rxErr was seen in the frame or rxFcsOk is low.
- R5: In store-and-forward mode (cutThrough = 0 at the first word), enqValid pulses in the same cycle as the final FIFO write if and only if the frame has at least 6 words, no rxErr and rxFcsOk = 1.
- R6: In cut-through mode, enqValid pulses after the first non-last word at which the accepted byte count reaches ctThreshold, provided at least 6 words have arrived and no rxErr has been seen. If the frame ends first, the rule of R5 applies on the last word.
- R7: A cut-through enqueue is never withdrawn. A later rxErr or a bad FCS causes neither a second enqValid nor a dropValid for that frame.
- R8: learnValid pulses with the final FIFO write exactly when the frame has at least 6 words, no rxErr and rxFcsOk = 1. learnSa is {word5, word4, word3}.
- R9: dropValid pulses with the final FIFO write when the frame has not been enqueued; enqValid and dropValid are never high together.
- R10: An rxErr on any word stops that frame from producing any later lookup, enqueue or learning pulse.
- R11: cutThrough and ctThreshold are taken at the first word of each frame; changes during the frame have no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cutThrough | input | 1 | 1 selects cut-through, 0 store-and-forward |
| ctThreshold | input | CNT_W | Cut-through byte threshold |
| rxValid | input | 1 | A word is offered this cycle |
| rxData | input | 16 | Frame word, first byte in bits 7:0 |
| rxLast | input | 1 | Word is the last of the frame |
| rxHalf | input | 1 | With rxLast: only the low byte is valid |
| rxErr | input | 1 | Receive error on this word |
| rxFcsOk | input | 1 | With rxLast: frame check sequence correct |
| lookupValid | output | 1 | Destination lookup request pulse |
| lookupDa | output | 48 | Destination address |
| fifoValid | output | 1 | Quad-word write pulse |
| fifoData | output | 64 | Packed quad-word |
| fifoBytes | output | 4 | Valid bytes in this write |
| fifoLast | output | 1 | Final write of the frame |
| fifoBad | output | 1 | Frame is errored or has a bad FCS |
| enqValid | output | 1 | Hand frame to output queue |
| learnValid | output | 1 | Source learning request pulse |
| learnSa | output | 48 | Source address |
| dropValid | output | 1 | Frame ended without being queued |

## Verification
The hardest states to reach are the cut-through cases where the threshold crossing falls next to another event: a threshold reached before the header is complete, on the last word itself, or followed later by an error or a bad FCS. The stimulus covers these with chosen thresholds (0, mid-frame, beyond the frame length) and chosen error positions. It also flips the mode input during a frame. A behavioural model counts bytes and words and predicts every pulse on every cycle, so each off-by-one in the crossing shows up as a cycle mismatch.

// File: rtl/ingress_pkg.sv
package ingress_pkg;
  localparam int WORD_W     = 16;
  localparam int QW_LANES   = 4;
  localparam int LANE_W     = $clog2(QW_LANES);
  localparam int QW_W       = WORD_W * QW_LANES;
  localparam int BYTES_W    = $clog2(2 * QW_LANES + 1);
  localparam int ADDR_W     = 48;
  localparam int ADDR_WORDS = ADDR_W / WORD_W;
  localparam int HDR_WORDS  = 2 * ADDR_WORDS;
  localparam int SLOT_W     = $clog2(HDR_WORDS + 2);

  // strobes from control to datapath, valid in the cycle a word is accepted
  typedef struct packed {
    logic              accept;
    logic [LANE_W-1:0] lane;
    logic [SLOT_W-1:0] hdrSlot;
    logic              lastWord;
    logic              halfLast;
    logic              markBad;
    logic              loadLookup;
    logic              loadLearn;
  } ingStrobe_t;
endpackage

// File: rtl/ingress_ctl.sv
module ingress_ctl
  import ingress_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cutThrough,
  input  logic [CNT_W-1:0] ctThreshold,
  input  logic             rxValid,
  input  logic             rxLast,
  input  logic             rxHalf,
  input  logic             rxErr,
  input  logic             rxFcsOk,
  output ingStrobe_t       strobe,
  output logic             lookupValid,
  output logic             enqValid,
  output logic             learnValid,
  output logic             dropValid
);
  logic              inFrame;
  logic [SLOT_W-1:0] wordCnt;
  logic [LANE_W-1:0] lane;
  logic [CNT_W-1:0]  byteCnt;
  logic              errSeen;
  logic              enqDone;
  logic              modeQ;
  logic [CNT_W-1:0]  thrQ;

  logic              firstWord, modeNow, errAny, hdrDone;
  logic [CNT_W-1:0]  thrNow, byteSat;
  logic [CNT_W:0]    byteSum;
  logic              ctHit, goodEnd, enqNow, dropNow, lookNow;

  always_comb begin
    firstWord = rxValid && !inFrame;
    modeNow   = firstWord ? cutThrough : modeQ;
    thrNow    = firstWord ? ctThreshold : thrQ;
    errAny    = errSeen || rxErr;
    hdrDone   = wordCnt >= SLOT_W'(HDR_WORDS - 1);
    byteSum   = {1'b0, byteCnt} + ((rxLast && rxHalf) ? (CNT_W+1)'(1) : (CNT_W+1)'(2));
    byteSat   = byteSum[CNT_W] ? {CNT_W{1'b1}} : byteSum[CNT_W-1:0];
    ctHit     = rxValid && !rxLast && modeNow && !enqDone && !errAny && hdrDone
                && (byteSat >= thrNow);
    goodEnd   = rxValid && rxLast && !errAny && rxFcsOk && hdrDone;
    enqNow    = ctHit || (goodEnd && !enqDone);
    dropNow   = rxValid && rxLast && !enqDone && !goodEnd;
    lookNow   = rxValid && (wordCnt == SLOT_W'(ADDR_WORDS - 1)) && !errAny;

    strobe.accept     = rxValid;
    strobe.lane       = lane;
    strobe.hdrSlot    = wordCnt;
    strobe.lastWord   = rxLast;
    strobe.halfLast   = rxLast && rxHalf;
    strobe.markBad    = rxLast && (errAny || !rxFcsOk);
    strobe.loadLookup = lookNow;
    strobe.loadLearn  = goodEnd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inFrame <= 1'b0;
      wordCnt <= '0;
      lane    <= '0;
      byteCnt <= '0;
      errSeen <= 1'b0;
      enqDone <= 1'b0;
      modeQ   <= 1'b0;
      thrQ    <= '0;
    end else if (rxValid) begin
      if (firstWord) begin
        modeQ <= cutThrough;
        thrQ  <= ctThreshold;
      end
      if (rxLast) begin
        inFrame <= 1'b0;
        wordCnt <= '0;
        lane    <= '0;
        byteCnt <= '0;
        errSeen <= 1'b0;
        enqDone <= 1'b0;
      end else begin
        inFrame <= 1'b1;
        if (wordCnt != SLOT_W'(HDR_WORDS)) wordCnt <= wordCnt + 1'b1;
        lane    <= lane + 1'b1;
        byteCnt <= byteSat;
        errSeen <= errAny;
        enqDone <= enqDone || enqNow;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lookupValid <= 1'b0;
      enqValid    <= 1'b0;
      learnValid  <= 1'b0;
      dropValid   <= 1'b0;
    end else begin
      lookupValid <= lookNow;
      enqValid    <= enqNow;
      learnValid  <= goodEnd;
      dropValid   <= dropNow;
    end
  end

  AST_LOOKUP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    lookupValid |=> !lookupValid); // R2
  AST_ENQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    enqValid |=> !enqValid); // R7
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (errSeen && !enqDone && rxValid) |=> (!enqValid && !learnValid && !lookupValid)); // R10
  AST_ENQ_DROP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    enqValid |-> !dropValid); // R9
endmodule

// File: rtl/ingress_dp.sv
module ingress_dp
  import ingress_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  ingStrobe_t         strobe,
  input  logic [WORD_W-1:0]  rxData,
  output logic [ADDR_W-1:0]  lookupDa,
  output logic [ADDR_W-1:0]  learnSa,
  output logic               fifoValid,
  output logic [QW_W-1:0]    fifoData,
  output logic [BYTES_W-1:0] fifoBytes,
  output logic               fifoLast,
  output logic               fifoBad
);
  logic [QW_W-1:0]    qwBuf;
  logic [WORD_W-1:0]  hdrW [HDR_WORDS];
  logic [WORD_W-1:0]  wordIn, lastSaWord;
  logic [QW_W-1:0]    merged;
  logic               emit;
  logic [BYTES_W-1:0] bytesNow;

  always_comb begin
    wordIn = strobe.halfLast ? {8'h00, rxData[7:0]} : rxData;
    merged = qwBuf;
    merged[strobe.lane*WORD_W +: WORD_W] = wordIn;
    emit = strobe.accept && (strobe.lastWord || (strobe.lane == LANE_W'(QW_LANES - 1)));
    bytesNow = BYTES_W'({strobe.lane, 1'b0})
             + (strobe.halfLast ? BYTES_W'(1) : BYTES_W'(2));
    lastSaWord = (strobe.hdrSlot == SLOT_W'(HDR_WORDS - 1)) ? wordIn : hdrW[HDR_WORDS-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qwBuf <= '0;
      for (int i = 0; i < HDR_WORDS; i++) hdrW[i] <= '0;
      lookupDa  <= '0;
      learnSa   <= '0;
      fifoValid <= 1'b0;
      fifoData  <= '0;
      fifoBytes <= '0;
      fifoLast  <= 1'b0;
      fifoBad   <= 1'b0;
    end else begin
      fifoValid <= emit;
      fifoLast  <= emit && strobe.lastWord;
      fifoBad   <= emit && strobe.markBad;
      if (emit) begin
        fifoData  <= merged;
        fifoBytes <= bytesNow;
      end
      if (strobe.accept) begin
        qwBuf <= emit ? '0 : merged;
        if (strobe.hdrSlot < SLOT_W'(HDR_WORDS)) hdrW[strobe.hdrSlot] <= wordIn;
      end
      if (strobe.loadLookup) lookupDa <= {wordIn, hdrW[1], hdrW[0]};
      if (strobe.loadLearn)  learnSa  <= {lastSaWord, hdrW[4], hdrW[3]};
    end
  end

  AST_FULL_MID_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (fifoValid && !fifoLast) |-> (fifoBytes == BYTES_W'(2 * QW_LANES))); // R3
  AST_BYTES_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fifoValid |-> (fifoBytes != '0 && fifoBytes <= BYTES_W'(2 * QW_LANES))); // R4
  AST_BAD_ONLY_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    fifoBad |-> (fifoValid && fifoLast)); // R4
endmodule

// File: rtl/port_ingress_ctrl.sv
module port_ingress_ctrl
  import ingress_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cutThrough,
  input  logic [CNT_W-1:0]   ctThreshold,
  input  logic               rxValid,
  input  logic [WORD_W-1:0]  rxData,
  input  logic               rxLast,
  input  logic               rxHalf,
  input  logic               rxErr,
  input  logic               rxFcsOk,
  output logic               lookupValid,
  output logic [ADDR_W-1:0]  lookupDa,
  output logic               fifoValid,
  output logic [QW_W-1:0]    fifoData,
  output logic [BYTES_W-1:0] fifoBytes,
  output logic               fifoLast,
  output logic               fifoBad,
  output logic               enqValid,
  output logic               learnValid,
  output logic [ADDR_W-1:0]  learnSa,
  output logic               dropValid
);
  ingStrobe_t strobe;

  ingress_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .cutThrough(cutThrough), .ctThreshold(ctThreshold),
    .rxValid(rxValid), .rxLast(rxLast), .rxHalf(rxHalf), .rxErr(rxErr),
    .rxFcsOk(rxFcsOk), .strobe(strobe), .lookupValid(lookupValid),
    .enqValid(enqValid), .learnValid(learnValid), .dropValid(dropValid)
  );

  ingress_dp u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .rxData(rxData),
    .lookupDa(lookupDa), .learnSa(learnSa), .fifoValid(fifoValid),
    .fifoData(fifoData), .fifoBytes(fifoBytes), .fifoLast(fifoLast),
    .fifoBad(fifoBad)
  );

  AST_LEARN_CLEAN_END: assert property (@(posedge clk) disable iff (!rst_n)
    learnValid |-> (fifoValid && fifoLast && !fifoBad)); // R8
  AST_DROP_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    dropValid |-> (fifoValid && fifoLast)); // R9
endmodule

// File: tb/port_ingress_ctrl_tb.sv
module port_ingress_ctrl_tb;
  localparam int CNT_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cutThrough = 1'b0;
  logic [CNT_W-1:0] ctThreshold = '0;
  logic rxValid = 1'b0;
  logic [15:0] rxData = '0;
  logic rxLast = 1'b0, rxHalf = 1'b0, rxErr = 1'b0, rxFcsOk = 1'b0;
  logic lookupValid, fifoValid, fifoLast, fifoBad, enqValid, learnValid, dropValid;
  logic [47:0] lookupDa, learnSa;
  logic [63:0] fifoData;
  logic [3:0]  fifoBytes;

  port_ingress_ctrl #(.CNT_W(CNT_W)) u_dut (.*);

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] pend[$];
  logic [7:0] fb[$];
  int  wcount = 0, btotal = 0, mThr = 0;
  bit  errS = 0, enqd = 0, mMode = 0, good = 0;
  bit  eLook = 0, eFifo = 0, eFLast = 0, eFBad = 0, eEnq = 0, eLearn = 0, eDrop = 0;
  logic [47:0] eDa = '0, eSa = '0;
  logic [63:0] eFData = '0;
  int  eFBytes = 0;
  bit  inReset = 1;

  function automatic logic [47:0] addrAt(int base);
    logic [47:0] a = '0;
    for (int i = 0; i < 6; i++) a[8*i +: 8] = (base + i < fb.size()) ? fb[base + i] : 8'h00;
    return a;
  endfunction

  always @(posedge clk) begin
    eLook = 0; eFifo = 0; eFLast = 0; eFBad = 0; eEnq = 0; eLearn = 0; eDrop = 0;
    if (!rst_n) begin
      pend.delete(); fb.delete(); wcount = 0; btotal = 0; errS = 0; enqd = 0;
    end else if (rxValid) begin
      if (wcount == 0) begin mMode = cutThrough; mThr = int'(ctThreshold); end
      if (rxErr) errS = 1;
      pend.push_back(rxData[7:0]);
      if (fb.size() < 12) fb.push_back(rxData[7:0]);
      btotal += 1;
      if (!(rxLast && rxHalf)) begin
        pend.push_back(rxData[15:8]);
        if (fb.size() < 12) fb.push_back(rxData[15:8]);
        btotal += 1;
      end
      wcount++;
      if (wcount == 3 && !errS) begin eLook = 1; eDa = addrAt(0); end
      if (pend.size() == 8 || rxLast) begin
        eFifo = 1; eFData = '0; eFBytes = pend.size();
        for (int i = 0; i < pend.size(); i++) eFData[8*i +: 8] = pend[i];
        eFLast = rxLast; eFBad = rxLast && (errS || !rxFcsOk);
        pend.delete();
      end
      if (!rxLast && mMode && !enqd && !errS && wcount >= 6 && btotal >= mThr) begin
        eEnq = 1; enqd = 1;
      end
      if (rxLast) begin
        good = !errS && rxFcsOk && wcount >= 6;
        if (good) begin
          eLearn = 1; eSa = addrAt(6);
          if (!enqd) eEnq = 1;
        end else if (!enqd) eDrop = 1;
        fb.delete(); wcount = 0; btotal = 0; errS = 0; enqd = 0;
      end
    end
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!finished) begin
      if (inReset) begin
        chk(!lookupValid && !fifoValid && !enqValid && !learnValid && !dropValid,
            "R1", "outputs idle in reset",
            {59'd0, lookupValid, fifoValid, enqValid, learnValid, dropValid}, 64'd0);
      end else begin
        chk(lookupValid == eLook, "R2 R10", "lookupValid", lookupValid, eLook);
        if (eLook) chk(lookupDa == eDa, "R2", "lookupDa", lookupDa, eDa);
        chk(fifoValid == eFifo, "R3", "fifoValid", fifoValid, eFifo);
        if (eFifo) begin
          chk(fifoData == eFData, "R3 R4", "fifoData", fifoData, eFData);
          chk(int'(fifoBytes) == eFBytes, "R3 R4", "fifoBytes", fifoBytes, eFBytes);
          chk(fifoLast == eFLast, "R4", "fifoLast", fifoLast, eFLast);
          chk(fifoBad == eFBad, "R4", "fifoBad", fifoBad, eFBad);
        end
        chk(enqValid == eEnq, "R5 R6 R7 R10 R11", "enqValid", enqValid, eEnq);
        chk(learnValid == eLearn, "R8 R10", "learnValid", learnValid, eLearn);
        if (eLearn) chk(learnSa == eSa, "R8", "learnSa", learnSa, eSa);
        chk(dropValid == eDrop, "R9 R7", "dropValid", dropValid, eDrop);
      end
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rxValid = 0; rxLast = 0; rxHalf = 0; rxErr = 0; rxFcsOk = 0;
    end
  endtask

  // n words; half: odd length; errAt: word carrying rxErr (-1 none);
  // gapMod: idle cycle after words where i%gapMod==1 (0 none); flipAt: toggle mode
  task automatic sendFrame(int n, bit half, int errAt, bit fcs, int seed, int gapMod, int flipAt);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (i == flipAt) cutThrough = ~cutThrough;
      rxValid = 1;
      rxData  = 16'((seed * 16'h1357) ^ (i * 16'h0a3b) ^ (i << 9));
      rxLast  = (i == n - 1);
      rxHalf  = (i == n - 1) && half;
      rxErr   = (i == errAt);
      rxFcsOk = (i == n - 1) ? fcs : 1'b0;
      if (gapMod != 0 && (i % gapMod) == 1 && i != n - 1) begin
        @(negedge clk);
        rxValid = 0; rxLast = 0; rxHalf = 0; rxErr = 0;
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;                 // R1 checked during reset and on the first cycle after
    @(negedge clk);
    inReset = 0;
    idle(2);
    // store-and-forward
    cutThrough = 0;
    sendFrame(10, 0, -1, 1, 1, 0, -1); idle(2);   // R5 R8 R3 clean even frame
    sendFrame(13, 1, -1, 1, 2, 0, -1); idle(2);   // R4 odd length partial quad
    sendFrame(9, 0, -1, 0, 3, 0, -1);  idle(2);   // R9 R4 bad FCS
    sendFrame(12, 0, 7, 1, 4, 0, -1);  idle(2);   // R10 error after lookup
    sendFrame(8, 0, 1, 1, 5, 0, -1);   idle(2);   // R10 error before lookup
    sendFrame(4, 0, -1, 1, 6, 0, -1);  idle(2);   // R9 short frame dropped
    sendFrame(6, 1, -1, 1, 7, 0, -1);  idle(2);   // R8 address ends on half word
    sendFrame(11, 0, -1, 1, 8, 3, -1); idle(2);   // R3 gaps inside frame
    // cut-through
    cutThrough = 1; ctThreshold = 20;
    sendFrame(16, 0, -1, 1, 9, 0, -1);  idle(2);  // R6 threshold crossing
    sendFrame(16, 0, 13, 1, 10, 0, -1); idle(2);  // R7 late error no revoke
    ctThreshold = 16;
    sendFrame(14, 1, -1, 0, 11, 0, -1); idle(2);  // R7 bad FCS after enqueue
    ctThreshold = 200;
    sendFrame(12, 0, -1, 1, 12, 0, -1); idle(2);  // R6 falls back to end rule
    ctThreshold = 0;
    sendFrame(9, 0, -1, 1, 13, 0, -1);  idle(2);  // R6 header gate with zero threshold
    ctThreshold = 12;
    sendFrame(6, 0, -1, 1, 14, 0, -1);  idle(2);  // R6 crossing on last word uses end rule
    sendFrame(10, 0, 3, 1, 15, 0, -1);  idle(2);  // R10 error before crossing
    // R11 mode flips mid-frame
    cutThrough = 1; ctThreshold = 14;
    sendFrame(14, 0, -1, 1, 16, 0, 2); idle(1);   // latched cut-through
    sendFrame(14, 0, -1, 1, 17, 0, 2); idle(1);   // latched store-and-forward
    // back-to-back frames, no idle between
    cutThrough = 1; ctThreshold = 10;
    sendFrame(8, 0, -1, 1, 18, 0, -1);
    sendFrame(7, 1, -1, 1, 19, 0, -1);
    sendFrame(9, 0, -1, 0, 20, 2, -1);
    idle(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule